// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single burst request into the column address used on each beat of an SDRAM read or write burst. A request carries a starting column, a three-bit length code, an ordering select (linear wrap or XOR interleave), a read/write flag and a one-location-write mode bit. From the clock after the request, the block shows one column per clock, flags each valid beat, and marks the final beat of any fixed-length burst.

A fixed-length burst of 2, 4 or 8 beats stays inside its aligned block of columns. Only the low bits that index the block vary; the bits above keep the values of the starting column. A full-page burst walks through the whole 8-bit row, wraps from the top column back to zero, and runs until it is stopped. A stop input ends any burst on the beat shown in that cycle. A new request arriving during a burst replaces it at once.

The controller uses three named states. IDLE shows no beat. BURST steps through a fixed-length burst. PAGE steps through a full-page burst. The transitions are: IDLE to BURST or PAGE on an accepted request. BURST to IDLE on its last beat or on a stop. PAGE to IDLE on a stop. Any busy state restarts into BURST or PAGE on an accepted request.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, and in every cycle with no valid beat, `beat_vld_o` is 0, `last_o` is 0 and `col_o` is 0.
- R2: A request is accepted when `start_i` is high at a clock edge and the length code is legal. The first beat then appears in the next cycle, with `col_o` equal to the starting column. The legal length codes are 3'b000 (1 beat), 3'b001 (2 beats), 3'b010 (4 beats), 3'b011 (8 beats) and 3'b111 (full page). A new beat follows on every clock.
- R3: With `ilv_i` = 0, beat k of a fixed-length burst of length L has low bits (start + k) mod L. For example, start offset 2 with length 4 gives 2,3,0,1.
- R4: With `ilv_i` = 1, beat k of a fixed-length burst has low bits equal to the start offset XOR k. For example, start offset 5 with length 8 gives 5,4,7,6,1,0,3,2.
- R5: Throughout a fixed-length burst, the column bits above the low log2(L) bits keep the values of the starting column.
- R6: `last_o` is high only on the final beat of a fixed-length burst. With no new request, `beat_vld_o` is 0 in the cycle after that beat.
- R7: In a full-page burst, each beat is the previous column plus one modulo 256, so 8'hFF is followed by 8'h00. `last_o` stays 0 and the burst continues until it is stopped.
- R8: When `stop_i` is high at a clock edge during a burst and no request is accepted, the beat shown in that cycle is the final one, and `beat_vld_o` is 0 in the next cycle. A stop with no burst running has no effect.
- R9: A request accepted during a burst abandons the burst. In the next cycle the first beat of the new burst appears. A request at the same edge as a stop takes priority over the stop.
- R10: When `is_write_i` = 1 and `single_wr_i` = 1, an accepted request gives a 1-beat burst whatever the length code. Reads with `single_wr_i` = 1 keep the coded length.
- R11: A request with a reserved length code (3'b100, 3'b101, 3'b110), or with the full-page code and `ilv_i` = 1, is ignored. No burst starts, and a burst already running continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | 8 | Starting column of the request |
| len_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| is_write_i | input | 1 | 1 = request is a write burst |
| single_wr_i | input | 1 | 1 = write bursts are one location long |
| stop_i | input | 1 | Ends the running burst on the current beat |
| col_o | output | 8 | Column of the current beat, 0 when no beat |
| beat_vld_o | output | 1 | A beat is shown this cycle |
| last_o | output | 1 | Current beat is the last of a fixed-length burst |

## Verification
The bench targets several corner cases, each matched to the fault it would expose:
- Start offsets near the top of their aligned block. A design that carries out of the low bits would corrupt the fixed upper bits.
- Odd interleaved offsets. A design that confuses XOR with addition would give 1-2-3-0 where 1-0-3-2 is due.
- A full-page run that crosses column 255. It shows whether the page wraps to zero and never raises the last flag.
- A stop mid-burst and a restart mid-burst. These catch a design that runs one beat too long or resumes the old burst.
- Reserved codes sent both idle and mid-burst. These catch a design that starts or disturbs a burst on an illegal request.
- One-location writes paired with full-length reads. These catch a mode bit applied to the wrong direction.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int BCG_COL_W   = 8;
    localparam int BCG_MAX_LOG = 3;

    localparam logic [2:0] LEN_ONE   = 3'b000;
    localparam logic [2:0] LEN_TWO   = 3'b001;
    localparam logic [2:0] LEN_FOUR  = 3'b010;
    localparam logic [2:0] LEN_EIGHT = 3'b011;
    localparam logic [2:0] LEN_PAGE  = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_t;

endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
    import bcg_pkg::*;
#(
    parameter int COL_W   = BCG_COL_W,
    parameter int MAX_LOG = BCG_MAX_LOG
) (
    input  logic [2:0]       code_i,
    input  logic             ilv_i,
    input  logic             is_write_i,
    input  logic             single_wr_i,
    output logic [COL_W-1:0] mask_o,
    output logic             page_o,
    output logic             legal_o
);

    logic             short_code;
    logic             page_code;
    logic             one_loc;
    logic [COL_W-1:0] mask_raw;

    assign short_code = (code_i == LEN_ONE) || (code_i == LEN_TWO) ||
                        (code_i == LEN_FOUR) || (code_i == LEN_EIGHT);
    assign page_code  = (code_i == LEN_PAGE);

    // full page is only defined for the sequential order
    assign legal_o    = short_code || (page_code && !ilv_i);
    assign one_loc    = is_write_i && single_wr_i;

    // bit i of the wrap mask is set when the burst spans 2^(i+1) or more beats
    for (genvar i = 0; i < COL_W; i++) begin : g_mask
        if (i < MAX_LOG) begin : g_low
            assign mask_raw[i] = page_code || (short_code && (int'(code_i) > i));
        end else begin : g_high
            assign mask_raw[i] = page_code;
        end
    end

    assign mask_o = one_loc ? '0 : mask_raw;
    assign page_o = page_code && !one_loc;

endmodule

// File: rtl/bcg_col_order.sv
module bcg_col_order
    import bcg_pkg::*;
#(
    parameter int COL_W = BCG_COL_W
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [COL_W-1:0] linear;

    // carries out of the masked field are discarded by the select below
    assign linear = base_i + beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        always_comb begin
            if (!mask_i[i]) begin
                col_o[i] = base_i[i];
            end else if (ilv_i) begin
                col_o[i] = base_i[i] ^ beat_i[i];
            end else begin
                col_o[i] = linear[i];
            end
        end
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import bcg_pkg::*;
#(
    parameter int COL_W   = BCG_COL_W,
    parameter int MAX_LOG = BCG_MAX_LOG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_code_i,
    input  logic             ilv_i,
    input  logic             is_write_i,
    input  logic             single_wr_i,
    input  logic             stop_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);

    bcg_state_t       state_q, state_d;
    logic [COL_W-1:0] base_q, mask_q, beat_q;
    logic             ilv_q;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page, dec_legal;
    logic             accept;
    logic             final_beat;
    logic [COL_W-1:0] col_w;
    logic             page_act;

    bcg_len_decode #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_dec (
        .code_i      (len_code_i),
        .ilv_i       (ilv_i),
        .is_write_i  (is_write_i),
        .single_wr_i (single_wr_i),
        .mask_o      (dec_mask),
        .page_o      (dec_page),
        .legal_o     (dec_legal)
    );

    bcg_col_order #(.COL_W(COL_W)) u_ord (
        .base_i (base_q),
        .beat_i (beat_q),
        .mask_i (mask_q),
        .ilv_i  (ilv_q),
        .col_o  (col_w)
    );

    assign accept     = start_i && dec_legal;
    assign final_beat = (beat_q == mask_q);
    assign page_act   = (state_q == ST_PAGE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = dec_page ? ST_PAGE : ST_BURST;
            end
            ST_BURST: begin
                if (accept)                    state_d = dec_page ? ST_PAGE : ST_BURST;
                else if (stop_i || final_beat) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (accept)      state_d = dec_page ? ST_PAGE : ST_BURST;
                else if (stop_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // burst context and beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            ilv_q  <= 1'b0;
            beat_q <= '0;
        end else if (accept) begin
            base_q <= start_col_i;
            mask_q <= dec_mask;
            ilv_q  <= ilv_i;
            beat_q <= '0;
        end else if (state_q != ST_IDLE) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        col_o      = '0;
        beat_vld_o = 1'b0;
        last_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BURST: begin
                col_o      = col_w;
                beat_vld_o = 1'b1;
                last_o     = final_beat;
            end
            ST_PAGE: begin
                col_o      = col_w;
                beat_vld_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker
    import bcg_pkg::*;
#(
    parameter int COL_W   = BCG_COL_W,
    parameter int MAX_LOG = BCG_MAX_LOG
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_vld_o,
    input logic             last_o,
    input logic             in_page
);

    localparam logic [COL_W-1:0] ONE = 1;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o |-> (!last_o && col_o == '0)); // R1

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i <= 3'd3) |=> (beat_vld_o && col_o == $past(start_col_i))); // R2

    AST_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld_o && !in_page && !start_i && !stop_i && !last_o)
        |=> (col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG]))); // R5

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !beat_vld_o); // R6

    AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        in_page |-> !last_o); // R7

    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_page && !start_i && !stop_i) |=> (beat_vld_o && col_o == $past(col_o) + ONE)); // R7

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i && beat_vld_o) |=> !beat_vld_o); // R8

endmodule

bind sdram_burst_colgen bcg_checker #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .len_code_i  (len_code_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .beat_vld_o  (beat_vld_o),
    .last_o      (last_o),
    .in_page     (page_act)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       ilv_i = 1'b0;
    logic       is_write_i = 1'b0;
    logic       single_wr_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_vld_o;
    logic       last_o;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    sdram_burst_colgen uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .is_write_i  (is_write_i),
        .single_wr_i (single_wr_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .last_o      (last_o)
    );

    typedef struct packed {
        logic [7:0]  col;
        logic [2:0]  code;
        logic        ilv;
        logic        wr;
        logic        single;
        logic [3:0]  len;
        logic [63:0] exp;   // first beat in the top byte
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h42, 3'd2, 1'b0, 1'b0, 1'b0, 4'd4, 64'h4243404100000000}, // R3 R5
        '{8'h15, 3'd3, 1'b0, 1'b0, 1'b0, 4'd8, 64'h1516171011121314}, // R3 R5
        '{8'h21, 3'd2, 1'b1, 1'b0, 1'b0, 4'd4, 64'h2120232200000000}, // R4
        '{8'hAD, 3'd3, 1'b1, 1'b0, 1'b0, 4'd8, 64'hADACAFAEA9A8ABAA}, // R4 R5
        '{8'h0E, 3'd3, 1'b1, 1'b0, 1'b0, 4'd8, 64'h0E0F0C0D0A0B0809}, // R4
        '{8'h37, 3'd1, 1'b0, 1'b0, 1'b0, 4'd2, 64'h3736000000000000}, // R3
        '{8'h37, 3'd1, 1'b1, 1'b0, 1'b0, 4'd2, 64'h3736000000000000}, // R4
        '{8'h9C, 3'd0, 1'b0, 1'b0, 1'b0, 4'd1, 64'h9C00000000000000}, // R2
        '{8'h13, 3'd3, 1'b0, 1'b1, 1'b1, 4'd1, 64'h1300000000000000}, // R10
        '{8'h13, 3'd3, 1'b0, 1'b0, 1'b1, 4'd8, 64'h1314151617101112}, // R10
        '{8'h06, 3'd2, 1'b0, 1'b1, 1'b0, 4'd4, 64'h0607040500000000}  // R10
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic req(input logic [7:0] col, input logic [2:0] code, input logic ilv,
                       input logic wr, input logic single);
        start_i     = 1'b1;
        start_col_i = col;
        len_code_i  = code;
        ilv_i       = ilv;
        is_write_i  = wr;
        single_wr_i = single;
        @(negedge clk);
        start_i     = 1'b0;
    endtask

    task automatic beat(input string tag, input logic [7:0] col, input logic last);
        chk({tag, " R2 valid"}, 8'(beat_vld_o), 8'h01);
        chk({tag, " column"}, col_o, col);
        chk({tag, " R6 last"}, 8'(last_o), 8'(last));
    endtask

    task automatic idle(input string tag);
        chk({tag, " valid low"}, 8'(beat_vld_o), 8'h00);
        chk({tag, " column zero"}, col_o, 8'h00);
    endtask

    initial begin
        // reset state
        repeat (3) @(negedge clk);
        idle("R1 in reset");
        chk("R1 last in reset", 8'(last_o), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        idle("R1 after reset");

        // vector table
        for (int v = 0; v < NV; v++) begin
            req(VECS[v].col, VECS[v].code, VECS[v].ilv, VECS[v].wr, VECS[v].single);
            for (int b = 0; b < int'(VECS[v].len); b++) begin
                beat($sformatf("R3/R4/R5/R10 vec %0d beat %0d", v, b),
                     VECS[v].exp[63-8*b -: 8], b == int'(VECS[v].len) - 1);
                @(negedge clk);
            end
            idle($sformatf("R6 vec %0d end", v));
            @(negedge clk);
        end

        // full page across the top column, then stopped
        req(8'hFD, 3'd7, 1'b0, 1'b0, 1'b0);
        for (int b = 0; b < 260; b++) begin
            beat("R7 page", 8'(8'hFD + b), 1'b0);
            if (b == 259) stop_i = 1'b1;
            @(negedge clk);
        end
        stop_i = 1'b0;
        idle("R8 page stop");
        @(negedge clk);

        // stop in a fixed burst
        req(8'h40, 3'd3, 1'b0, 1'b0, 1'b0);
        beat("R8 pre", 8'h40, 1'b0);
        @(negedge clk);
        beat("R8 pre", 8'h41, 1'b0);
        @(negedge clk);
        beat("R8 stop beat", 8'h42, 1'b0);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        idle("R8 after stop");

        // stop with nothing running
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        idle("R8 idle stop");
        @(negedge clk);

        // restart in mid burst, stop at the same edge loses to start
        req(8'h50, 3'd3, 1'b0, 1'b0, 1'b0);
        beat("R9 old", 8'h50, 1'b0);
        @(negedge clk);
        beat("R9 old", 8'h51, 1'b0);
        stop_i = 1'b1;
        req(8'h66, 3'd2, 1'b1, 1'b0, 1'b0);
        stop_i = 1'b0;
        beat("R9 new", 8'h66, 1'b0);
        @(negedge clk);
        beat("R9 new", 8'h67, 1'b0);
        @(negedge clk);
        beat("R9 new", 8'h64, 1'b0);
        @(negedge clk);
        beat("R9 new", 8'h65, 1'b1);
        @(negedge clk);
        idle("R9 end");

        // illegal requests while idle
        req(8'h77, 3'b101, 1'b0, 1'b0, 1'b0);
        idle("R11 reserved code");
        req(8'h77, 3'b111, 1'b1, 1'b0, 1'b0);
        idle("R11 page interleaved");
        @(negedge clk);

        // illegal request in mid burst
        req(8'h30, 3'd2, 1'b0, 1'b0, 1'b0);
        beat("R11 run", 8'h30, 1'b0);
        req(8'h99, 3'b110, 1'b0, 1'b0, 1'b0);
        beat("R11 run", 8'h31, 1'b0);
        @(negedge clk);
        beat("R11 run", 8'h32, 1'b0);
        @(negedge clk);
        beat("R11 run", 8'h33, 1'b1);
        @(negedge clk);
        idle("R11 end");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule